// File: doc/BRIEF.md
# Strap-Mode Capture and Shared Interrupt Pins

This block sits between four active-low board pins and the processor core. While the external reset is held low, the pins are treated as strap inputs. When reset is released, their value is captured once into a 4-bit mode register, which tells the core which of sixteen start-up configurations to take. From then on, the same pins act as maskable interrupt requests. Each line is set either to level detection or to falling-edge detection.

Reset is asserted asynchronously and released through a two-stage synchronizer, so start-up is exact to the cycle when the release edge is itself synchronous. Every pin passes through its own two-flop synchronizer before any logic uses it.

A falling edge on an edge-configured line leaves a sticky pending flag, which stays set until an acknowledge pulse clears it. A level-configured line is pending for as long as its synchronized sample is low. There are two wake outputs. The wake for the wait state follows the unmasked requests only. The wake for the stop standby state follows every pending line, whether it is masked or not.

Top module: `strap_irq_pins`

## Requirements
- R1: While `rst_n` is low, `sys_rst_n`, `mode`, `pending`, `irq_req`, `wait_wake` and `stop_wake` are all 0.
- R2: After `rst_n` rises, `sys_rst_n` stays 0 through the first rising clock edge and is 1 after the second.
- R3: On the third rising edge after `rst_n` rises, `mode[i]` takes the inverse of `pin_n[i]` as held during reset, so a low pin reads as 1.
- R4: Once captured, `mode` ignores every later change on `pin_n` until the next reset.
- R5: A line with `trig_sel[i]=0` (level) shows `pending[i]=1` from the second rising edge after its pin goes low. The flag clears on the second rising edge after the pin goes high.
- R6: On a line with `trig_sel[i]=1` (falling edge), a high-to-low pin transition sets `pending[i]` on the third rising edge. The flag stays set after the pin returns high.
- R7: `irq_ack[i]=1` clears an edge-pending flag on the next rising edge.
- R8: `irq_req = pending & ~irq_mask`. A masked edge line still records its pending flag.
- R9: `wait_wake` is 1 exactly when some bit of `irq_req` is 1.
- R10: `stop_wake` is 1 exactly when some bit of `pending` is 1, whatever the mask.
- R11: An edge-configured pin that is held low across reset release does not produce a pending flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_n | input | 4 | Active-low strap / interrupt pins |
| trig_sel | input | 4 | Per line: 0 = level, 1 = falling edge |
| irq_mask | input | 4 | Per line: 1 = masked |
| irq_ack | input | 4 | Per line: clears an edge-pending flag |
| sys_rst_n | output | 1 | Synchronized internal reset, active low |
| mode | output | 4 | Captured start-up mode code |
| pending | output | 4 | Pending flags, mask not applied |
| irq_req | output | 4 | Unmasked interrupt requests |
| wait_wake | output | 1 | Wake from wait state |
| stop_wake | output | 1 | Wake from stop state |

## Verification
The embedded properties are checked on every clock. They cover the following:
- the reset-time output values;
- the synchronized reset rising only after the external reset was already high;
- the mode register staying frozen once it has been captured;
- sticky flags holding until they are acknowledged, and clearing on acknowledge;
- a wait wake always implying a stop wake.

Some behaviours only the directed scenarios can show:
- the exact cycle latencies of capture and of level and edge detection;
- the inversion and bit order of the mode code;
- the absence of a false edge across reset release;
- the effect of the mask on each wake output.

// File: rtl/strap_irq_pkg.sv
package strap_irq_pkg;
  typedef enum logic {
    TRIG_LEVEL = 1'b0,
    TRIG_FALL  = 1'b1
  } trig_e;

  localparam int unsigned DEF_LINES  = 4;
  localparam int unsigned DEF_STAGES = 2;
endpackage

// File: rtl/strap_rst_sync.sv
module strap_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sh_q, sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= sh_d;
  end

  assign srst_n = sh_q[STAGES-1];

  // R2
  rst_release_chk: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(srst_n) |-> $past(arst_n));
endmodule

// File: rtl/strap_pin_sync.sv
module strap_pin_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [STAGES-1:0][WIDTH-1:0] stg_q, stg_d;

  always_comb begin
    stg_d[0] = din;
    for (int s = 1; s < STAGES; s++) stg_d[s] = stg_q[s-1];
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stg_q <= '1;
    else         stg_q <= stg_d;
  end

  assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/strap_irq_line.sv
module strap_irq_line
  import strap_irq_pkg::*;
(
  input  logic clk,
  input  logic srst_n,
  input  logic armed,
  input  logic pin_s,
  input  logic trig,
  input  logic ack,
  output logic pend
);
  logic prev_q, prev_d;
  logic flag_q, flag_d;
  logic fall_set;
  logic lvl_pend;
  logic is_edge;

  assign is_edge  = (trig_e'(trig) == TRIG_FALL);
  assign fall_set = armed & is_edge & prev_q & ~pin_s;
  assign lvl_pend = armed & ~is_edge & ~pin_s;

  always_comb begin
    prev_d = pin_s;
    flag_d = fall_set | (flag_q & ~ack);
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      prev_q <= 1'b1;
      flag_q <= 1'b0;
    end else begin
      prev_q <= prev_d;
      flag_q <= flag_d;
    end
  end

  assign pend = flag_q | lvl_pend;

  // R6
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (flag_q && !ack) |=> flag_q);

  // R7
  ack_clear_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (ack && !fall_set) |=> !flag_q);
endmodule

// File: rtl/strap_irq_pins.sv
module strap_irq_pins
  import strap_irq_pkg::*;
#(
  parameter int unsigned LINES  = DEF_LINES,
  parameter int unsigned STAGES = DEF_STAGES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] pin_n,
  input  logic [LINES-1:0] trig_sel,
  input  logic [LINES-1:0] irq_mask,
  input  logic [LINES-1:0] irq_ack,
  output logic             sys_rst_n,
  output logic [LINES-1:0] mode,
  output logic [LINES-1:0] pending,
  output logic [LINES-1:0] irq_req,
  output logic             wait_wake,
  output logic             stop_wake
);
  logic             srst_n;
  logic [LINES-1:0] pin_s;
  logic             cap_q, cap_d;
  logic [LINES-1:0] mode_q, mode_d;
  logic             cap_en;

  strap_rst_sync #(.STAGES(STAGES)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  strap_pin_sync #(.WIDTH(LINES), .STAGES(STAGES)) u_pins (
    .clk    (clk),
    .arst_n (rst_n),
    .din    (pin_n),
    .dout   (pin_s)
  );

  assign cap_en = ~cap_q;

  always_comb begin
    cap_d  = cap_q;
    mode_d = mode_q;
    if (cap_en) begin
      cap_d  = 1'b1;
      mode_d = ~pin_s;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      cap_q  <= 1'b0;
      mode_q <= '0;
    end else begin
      cap_q  <= cap_d;
      mode_q <= mode_d;
    end
  end

  for (genvar i = 0; i < LINES; i++) begin : g_line
    strap_irq_line u_line (
      .clk    (clk),
      .srst_n (srst_n),
      .armed  (cap_q),
      .pin_s  (pin_s[i]),
      .trig   (trig_sel[i]),
      .ack    (irq_ack[i]),
      .pend   (pending[i])
    );
  end

  assign irq_req   = pending & ~irq_mask;
  assign wait_wake = |irq_req;
  assign stop_wake = |pending;
  assign mode      = mode_q;
  assign sys_rst_n = srst_n;

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> (mode == '0 && pending == '0 && !sys_rst_n));

  // R4
  mode_frozen_chk: assert property (@(posedge clk) disable iff (!srst_n)
    cap_q |=> $stable(mode_q));

  // R10
  wake_order_chk: assert property (@(posedge clk) disable iff (!srst_n)
    wait_wake |-> stop_wake);
endmodule

// File: tb/test_strap_irq_pins.sv
module test_strap_irq_pins;
  localparam int CLK_P = 10;

  logic       clk;
  logic       rst_n;
  logic [3:0] pin_n, trig_sel, irq_mask, irq_ack;
  logic       sys_rst_n, wait_wake, stop_wake;
  logic [3:0] mode, pending, irq_req;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  strap_irq_pins i_strap_irq_pins (
    .clk(clk), .rst_n(rst_n), .pin_n(pin_n), .trig_sel(trig_sel),
    .irq_mask(irq_mask), .irq_ack(irq_ack), .sys_rst_n(sys_rst_n),
    .mode(mode), .pending(pending), .irq_req(irq_req),
    .wait_wake(wait_wake), .stop_wake(stop_wake)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic reset_seq(input logic [3:0] straps, input logic [3:0] trig);
    @(negedge clk);
    rst_n = 1'b0; pin_n = straps; trig_sel = trig; irq_mask = '0; irq_ack = '0;
    wait_n(3);
    check(sys_rst_n == 0 && mode == 0, "R1 rst/mode", {sys_rst_n, mode}, 0);
    check(pending == 0 && irq_req == 0 && !wait_wake && !stop_wake, "R1 outputs",
          {pending, irq_req, wait_wake, stop_wake}, 0);
    rst_n = 1'b1;
    wait_n(1);
    check(sys_rst_n == 0, "R2 first edge", sys_rst_n, 0);
    wait_n(1);
    check(sys_rst_n == 1, "R2 second edge", sys_rst_n, 1);
    check(mode == 0, "R3 before capture", mode, 0);
    wait_n(1);
    check(mode == ~straps, "R3 capture", mode, ~straps);
  endtask

  task automatic t_mode_capture;
    reset_seq(4'b1010, 4'b0000);
    reset_seq(4'b0011, 4'hF);
    pin_n = 4'b1111;
    wait_n(4);
    check(mode == 4'b1100, "R4 hold after pins rise", mode, 4'b1100);
    pin_n = 4'b0110;
    wait_n(4);
    check(mode == 4'b1100, "R4 hold after pins toggle", mode, 4'b1100);
    pin_n = 4'b1111;
    wait_n(4);
  endtask

  task automatic t_no_false_edge;
    reset_seq(4'b0000, 4'hF);
    wait_n(5);
    check(pending == 0, "R11 no pending from held-low pins", pending, 0);
    pin_n = 4'hF;
    wait_n(4);
  endtask

  task automatic t_level;
    reset_seq(4'hF, 4'h0);
    pin_n[1] = 1'b0;
    wait_n(1);
    check(pending == 0, "R5 level one edge", pending, 0);
    wait_n(1);
    check(pending == 4'b0010, "R5 level pending", pending, 4'b0010);
    check(irq_req == 4'b0010, "R8 level req", irq_req, 4'b0010);
    check(wait_wake && stop_wake, "R9 R10 wakes", {wait_wake, stop_wake}, 2'b11);
    pin_n[1] = 1'b1;
    wait_n(1);
    check(pending == 4'b0010, "R5 level still set", pending, 4'b0010);
    wait_n(1);
    check(pending == 0, "R5 level cleared", pending, 0);
    irq_mask = 4'b0001;
    pin_n[0] = 1'b0;
    wait_n(2);
    check(!wait_wake && stop_wake, "R9 R10 masked level",
          {wait_wake, stop_wake}, 2'b01);
    pin_n[0] = 1'b1; irq_mask = 0;
    wait_n(3);
  endtask

  task automatic t_edge;
    reset_seq(4'hF, 4'hF);
    pin_n[2] = 1'b0;
    wait_n(2);
    check(pending == 0, "R6 edge two edges", pending, 0);
    wait_n(1);
    check(pending == 4'b0100, "R6 edge set", pending, 4'b0100);
    pin_n[2] = 1'b1;
    wait_n(4);
    check(pending == 4'b0100, "R6 sticky", pending, 4'b0100);
    irq_ack = 4'b0100;
    wait_n(1);
    irq_ack = 0;
    check(pending == 0, "R7 ack clears", pending, 0);
  endtask

  task automatic t_mask;
    irq_mask = 4'b1000;
    pin_n[3] = 1'b0;
    wait_n(3);
    check(pending == 4'b1000, "R8 masked still pending", pending, 4'b1000);
    check(irq_req == 0, "R8 masked no req", irq_req, 0);
    check(!wait_wake, "R9 masked no wait wake", wait_wake, 0);
    check(stop_wake, "R10 masked stop wake", stop_wake, 1);
    irq_mask = 0;
    #1;
    check(irq_req == 4'b1000 && wait_wake, "R8 R9 unmask",
          {irq_req, wait_wake}, {4'b1000, 1'b1});
    pin_n[3] = 1'b1;
    irq_ack = 4'b1000;
    @(negedge clk);
    irq_ack = 0;
    check(pending == 0 && !stop_wake, "R7 R10 cleared", {pending, stop_wake}, 0);
  endtask

  initial begin
    rst_n = 1'b0; pin_n = '1; trig_sel = '0; irq_mask = '0; irq_ack = '0;
    t_mode_capture();
    t_no_false_edge();
    t_level();
    t_edge();
    t_mask();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule